// File: doc/BRIEF.md
# Four-Channel Staggered PWM Switch Driver

This block produces the enable and fault-control levels for four high-side switches. Each switch can be driven in one of two ways. In direct mode it follows an external pin, gated by a per-channel mask, together with a software on bit. In PWM mode it follows a 128-step waveform whose width is set per channel by a 7-bit duty code. Each channel's waveform can be started later than the others by a multiple of 16 ticks, so the four switches do not all turn on in the same tick. This spreads the switching edges and lowers emission peaks.

The PWM tick is a single-cycle strobe in the system clock domain. It comes either from an external-input strobe or from an internal-clock strobe. When the external source is chosen, that input pin carries the clock, and none of the direct pins can drive a switch. A clock-fail flag stops the waveform, and each output then follows its on bit. Duty and delay codes are copied into shadow registers only when the shared phase counter wraps. A code written in the middle of a period therefore cannot cut a pulse short.

Top module: `stagger_pwm4`

## Requirements
- R1: After reset, the shared phase counter is 0 and every shadow duty and delay code is 0. With all inputs low, both output buses are 0.
- R2: The phase counter is 7 bits wide and counts 0 to 127, then back to 0. It advances by one only in a cycle where the selected tick strobe is 1 and `clkFail` is 0.
- R3: In PWM mode (`pwmEn`=1, `clkFail`=0), a channel whose on bit is set and whose shadow duty is n drives `hsEnable` high while its local phase is in 0..n. That is n+1 ticks out of 128.
- R4: A channel's local phase is (counter − 16·d) mod 128, where d is its 3-bit shadow delay code. Code 0 gives no shift and code 7 shifts by 112 ticks.
- R5: Duty code 127 holds `hsEnable` high for the whole period.
- R6: In PWM mode, a channel whose on bit is 0 has `hsEnable` low.
- R7: With `pwmEn`=0, hsEnable[x] = (pin[x] & pinGate[x]) | onBits[x], where pin is the effective direct input.
- R8: `clkSel`=1 takes the tick from `extTick`, and the effective direct input is 0 on all four channels. `clkSel`=0 takes the tick from `intTick` and passes `dirIn` through unchanged.
- R9: With `pwmEn`=1 and `clkFail`=1, hsEnable equals `onBits`, and the phase counter holds its value.
- R10: faultCtl[x] = (~pwmEn & pin[x] & pinGate[x]) | onBits[x].
- R11: Channel x occupies bits [7x+6:7x] of `dutyCodes` and bits [3x+2:3x] of `delayCodes`. Both are copied into the shadow registers only at a counted tick in which the counter was 127. A change at any other time has no effect until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extTick | input | 1 | PWM tick strobe from the external input pin |
| intTick | input | 1 | PWM tick strobe from the internal clock |
| clkSel | input | 1 | 1 selects extTick and blocks the direct pins |
| clkFail | input | 1 | Tick source failed; stops the waveform |
| pwmEn | input | 1 | 1 for PWM mode, 0 for direct mode |
| dirIn | input | 4 | Direct control pins, one per channel |
| pinGate | input | 4 | Per-channel mask that lets a direct pin through |
| onBits | input | 4 | Per-channel on bits |
| dutyCodes | input | 28 | Four 7-bit duty codes |
| delayCodes | input | 12 | Four 3-bit phase-delay codes |
| hsEnable | output | 4 | Switch enable per channel |
| faultCtl | output | 4 | Fault-control enable per channel |

## Verification
The assertions treat the tick strobes, mode bits and code buses as synchronous to `clk` and stable between edges. The output equations are combinational in those inputs, so the properties compare levels within the same cycle. The stimulus changes every input one time unit after a rising edge. It drives the external strobe on one cycle in three and the internal strobe on every cycle, which keeps both sources inside those limits. Duty and delay codes change in the middle of a period on purpose, to exercise the shadow-load rule.

// File: rtl/stagger_pwm4_pkg.sv
package stagger_pwm4_pkg;
  // strobes the control half hands to the datapath half
  typedef struct packed {
    logic tick;   // counted PWM tick this cycle
    logic wrap;   // counted tick while the counter sits at its last value
  } ctlStrobe_t;
endpackage

// File: rtl/stagger_pwm4_ctl.sv
module stagger_pwm4_ctl
  import stagger_pwm4_pkg::*;
#(
  parameter int PHW = 7
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           extTick,
  input  logic           intTick,
  input  logic           clkSel,
  input  logic           clkFail,
  output ctlStrobe_t     strobe,
  output logic [PHW-1:0] phaseCnt
);
  logic selTick;

  always_comb begin
    selTick     = clkSel ? extTick : intTick;
    strobe.tick = selTick & ~clkFail;
    strobe.wrap = strobe.tick & (&phaseCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            phaseCnt <= '0;
    else if (strobe.tick) phaseCnt <= phaseCnt + 1'b1;
  end
endmodule

// File: rtl/stagger_pwm4_dp.sv
module stagger_pwm4_dp
  import stagger_pwm4_pkg::*;
#(
  parameter int CH    = 4,
  parameter int PHW   = 7,
  parameter int DLYW  = 3,
  parameter int STEPW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [PHW-1:0]    phaseCnt,
  input  logic              clkSel,
  input  logic              clkFail,
  input  logic              pwmEn,
  input  logic [CH-1:0]     dirIn,
  input  logic [CH-1:0]     pinGate,
  input  logic [CH-1:0]     onBits,
  input  logic [CH*PHW-1:0] dutyCodes,
  input  logic [CH*DLYW-1:0] delayCodes,
  output logic [CH-1:0]     hsEnable,
  output logic [CH-1:0]     faultCtl
);
  localparam int OFFW = DLYW + STEPW;

  logic [CH-1:0] pinEff;
  logic [CH-1:0] wave;

  assign pinEff = clkSel ? '0 : dirIn;

  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic [PHW-1:0]  shDuty;
    logic [DLYW-1:0] shDly;
    logic [OFFW-1:0] offset;
    logic [PHW-1:0]  localPh;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shDuty <= '0;
        shDly  <= '0;
      end else if (strobe.wrap) begin
        shDuty <= dutyCodes[i*PHW +: PHW];
        shDly  <= delayCodes[i*DLYW +: DLYW];
      end
    end

    always_comb begin
      offset  = {shDly, {STEPW{1'b0}}};
      localPh = phaseCnt - PHW'(offset);
      wave[i] = (localPh <= shDuty);
    end

    always_comb begin
      if (!pwmEn)      hsEnable[i] = (pinEff[i] & pinGate[i]) | onBits[i];
      else if (clkFail) hsEnable[i] = onBits[i];
      else             hsEnable[i] = onBits[i] & wave[i];
      faultCtl[i] = (~pwmEn & pinEff[i] & pinGate[i]) | onBits[i];
    end
  end
endmodule

// File: rtl/stagger_pwm4.sv
module stagger_pwm4
  import stagger_pwm4_pkg::*;
#(
  parameter int CH    = 4,
  parameter int PHW   = 7,
  parameter int DLYW  = 3,
  parameter int STEPW = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extTick,
  input  logic               intTick,
  input  logic               clkSel,
  input  logic               clkFail,
  input  logic               pwmEn,
  input  logic [CH-1:0]      dirIn,
  input  logic [CH-1:0]      pinGate,
  input  logic [CH-1:0]      onBits,
  input  logic [CH*PHW-1:0]  dutyCodes,
  input  logic [CH*DLYW-1:0] delayCodes,
  output logic [CH-1:0]      hsEnable,
  output logic [CH-1:0]      faultCtl
);
  ctlStrobe_t     strobe;
  logic [PHW-1:0] phaseCnt;

  stagger_pwm4_ctl #(.PHW(PHW)) u_ctl (
    .clk(clk), .rstN(rstN), .extTick(extTick), .intTick(intTick),
    .clkSel(clkSel), .clkFail(clkFail), .strobe(strobe), .phaseCnt(phaseCnt)
  );

  stagger_pwm4_dp #(.CH(CH), .PHW(PHW), .DLYW(DLYW), .STEPW(STEPW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .phaseCnt(phaseCnt),
    .clkSel(clkSel), .clkFail(clkFail), .pwmEn(pwmEn), .dirIn(dirIn),
    .pinGate(pinGate), .onBits(onBits), .dutyCodes(dutyCodes),
    .delayCodes(delayCodes), .hsEnable(hsEnable), .faultCtl(faultCtl)
  );
endmodule

// File: rtl/stagger_pwm4_chk.sv
module stagger_pwm4_chk #(
  parameter int CH = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          clkSel,
  input logic          clkFail,
  input logic          pwmEn,
  input logic [CH-1:0] dirIn,
  input logic [CH-1:0] pinGate,
  input logic [CH-1:0] onBits,
  input logic [CH-1:0] hsEnable,
  input logic [CH-1:0] faultCtl
);
  a_r6_off_without_on: assert property (@(posedge clk) disable iff (!rstN)
    pwmEn |-> ((hsEnable & ~onBits) == '0));

  a_r9_fail_follows_on: assert property (@(posedge clk) disable iff (!rstN)
    (pwmEn && clkFail) |-> (hsEnable == onBits));

  a_r8_pins_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (!pwmEn && clkSel) |-> (hsEnable == onBits && faultCtl == onBits));

  a_r10_fault_covers_on: assert property (@(posedge clk) disable iff (!rstN)
    ((faultCtl & onBits) == onBits));

  a_r7_direct_mode: assert property (@(posedge clk) disable iff (!rstN)
    (!pwmEn && !clkSel) |-> (hsEnable == ((dirIn & pinGate) | onBits)));

  a_r10_pwm_fault_is_on: assert property (@(posedge clk) disable iff (!rstN)
    pwmEn |-> (faultCtl == onBits));
endmodule

bind stagger_pwm4 stagger_pwm4_chk #(.CH(CH)) u_chk (
  .clk(clk), .rstN(rstN), .clkSel(clkSel), .clkFail(clkFail), .pwmEn(pwmEn),
  .dirIn(dirIn), .pinGate(pinGate), .onBits(onBits),
  .hsEnable(hsEnable), .faultCtl(faultCtl)
);

// File: tb/stagger_pwm4_bench.sv
`timescale 1ns/1ps
module stagger_pwm4_bench;
  logic clk = 0;
  logic rstN = 0;
  logic extTick = 0, intTick = 0, clkSel = 0, clkFail = 0, pwmEn = 0;
  logic [3:0] dirIn = 0, pinGate = 0, onBits = 0;
  logic [27:0] dutyCodes = 0;
  logic [11:0] delayCodes = 0;
  logic [3:0] hsEnable, faultCtl;

  int checks = 0, errors = 0;
  bit done = 0;
  string curTag = "R1";

  // reference model state
  int mCnt = 0;
  int mDuty [4] = '{0, 0, 0, 0};
  int mDly  [4] = '{0, 0, 0, 0};
  int extPh = 0;

  always #5 clk = ~clk;

  stagger_pwm4 u_stagger_pwm4 (
    .clk(clk), .rstN(rstN), .extTick(extTick), .intTick(intTick),
    .clkSel(clkSel), .clkFail(clkFail), .pwmEn(pwmEn), .dirIn(dirIn),
    .pinGate(pinGate), .onBits(onBits), .dutyCodes(dutyCodes),
    .delayCodes(delayCodes), .hsEnable(hsEnable), .faultCtl(faultCtl)
  );

  // model: counted tick, wrap at 127 with shadow load (R2, R11)
  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0;
      for (int i = 0; i < 4; i++) begin mDuty[i] = 0; mDly[i] = 0; end
    end else begin
      bit t;
      t = !clkFail && (clkSel ? extTick : intTick);
      if (t) begin
        if (mCnt == 127) begin
          mCnt = 0;
          for (int i = 0; i < 4; i++) begin
            mDuty[i] = (dutyCodes >> (7*i)) & 7'h7f;
            mDly[i]  = (delayCodes >> (3*i)) & 3'h7;
          end
        end else mCnt = mCnt + 1;
      end
    end
  end

  // external strobe one cycle in three
  always @(posedge clk) begin
    #1;
    extPh = (extPh + 1) % 3;
    extTick = (extPh == 0);
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      logic [3:0] expEn, expFc;
      for (int i = 0; i < 4; i++) begin
        bit pin, wv;
        int lp;
        pin = clkSel ? 1'b0 : dirIn[i];
        lp  = ((mCnt - 16*mDly[i]) % 128 + 128) % 128;
        wv  = (lp <= mDuty[i]);
        if (!pwmEn)       expEn[i] = (pin & pinGate[i]) | onBits[i];
        else if (clkFail) expEn[i] = onBits[i];
        else              expEn[i] = onBits[i] & wv;
        expFc[i] = (!pwmEn & pin & pinGate[i]) | onBits[i];
      end
      checks++;
      if (hsEnable !== expEn) begin
        errors++;
        $display("FAIL %s hsEnable got %b exp %b (cnt %0d)", curTag, hsEnable, expEn, mCnt);
      end
      checks++;
      if (faultCtl !== expFc) begin
        errors++;
        $display("FAIL R10 faultCtl got %b exp %b", faultCtl, expFc);
      end
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    intTick = 1;
    curTag = "R1";
    waitCyc(3);
    rstN = 1;
    waitCyc(5);

    // direct mode, pins gated (R7)
    intTick = 0;
    curTag = "R7";
    pwmEn = 0; dirIn = 4'b1011; pinGate = 4'b0110; onBits = 4'b0001;
    waitCyc(10);
    dirIn = 4'b1111; pinGate = 4'b1001; onBits = 4'b0100;
    waitCyc(10);

    // external clock selected: pins blocked (R8)
    curTag = "R8";
    clkSel = 1; dirIn = 4'b1111; pinGate = 4'b1111; onBits = 4'b0010;
    waitCyc(10);

    // PWM on external ticks, shadows load at first wrap (R2 R8 R11)
    curTag = "R2 R8 R11";
    pwmEn = 1; onBits = 4'b1111;
    dutyCodes  = {7'd0, 7'd127, 7'd63, 7'd5};
    delayCodes = {3'd3, 3'd7, 3'd1, 3'd0};
    waitCyc(800);

    // internal ticks, staggered phases, duty sweep (R3 R4 R5)
    curTag = "R3 R4 R5";
    clkSel = 0; intTick = 1;
    waitCyc(300);
    dutyCodes  = {7'd100, 7'd1, 7'd126, 7'd127};
    delayCodes = {3'd7, 3'd2, 3'd5, 3'd4};
    waitCyc(300);

    // on bits cleared on two channels (R6)
    curTag = "R6";
    onBits = 4'b0101;
    waitCyc(200);

    // mid-period code change held back until wrap (R11)
    curTag = "R11";
    onBits = 4'b1111;
    waitCyc(40);
    dutyCodes  = {7'd10, 7'd20, 7'd30, 7'd40};
    delayCodes = {3'd1, 3'd2, 3'd3, 3'd6};
    waitCyc(300);

    // clock failure freezes counter, outputs follow on bits (R9)
    curTag = "R9";
    clkFail = 1; onBits = 4'b1010;
    waitCyc(60);
    curTag = "R9 R2";
    clkFail = 0; onBits = 4'b1111;
    waitCyc(200);

    // direct mode faults with pins (R10)
    curTag = "R10 R7";
    pwmEn = 0; dirIn = 4'b0110; pinGate = 4'b0111; onBits = 4'b1000;
    waitCyc(10);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule